// File: doc/BRIEF.md
# Split-Section Binary Ripple Counter

This block is a four-bit binary counter divided into two independent sections. A single-bit section toggles on each falling edge of its own count input. A multi-bit section, three bits wide by default, counts up in binary on each falling edge of a second count input. Inside the wide section each bit toggles when the bit below it falls, as in a ripple chain, but the carry settles within one system clock, so the outputs never pass through intermediate states.

Both count inputs are plain levels that are sampled on a fast system clock, and their falling edges are detected in that clock domain. A two-input AND-gated clear forces both sections to zero and wins over any count edge. Wiring the single-bit output back to the wide section's count input gives a modulo-16 counter. Driving the wide section on its own gives divide-by-2, by-4 and by-8 outputs, while the single bit can still be used separately as a divide-by-two. All state is registered and the outputs come directly from flops.

Top module: `ripple_split_counter`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, both `q_lo` and `q_hi` are 0 after that edge.
- R2: When `lo_in` is 1 at one rising `clk` edge and 0 at the next, `q_lo` inverts after the second edge.
- R3: A rising edge or a steady level on `lo_in` or `hi_in` leaves the outputs unchanged.
- R4: Each falling edge of `hi_in` adds one to `q_hi`, detected in the same way as in R2, and 7 wraps to 0. Bit k of `q_hi` toggles exactly when bit k-1 goes from 1 to 0, and bit 0 toggles on every edge.
- R5: The two sections are independent. Edges on `lo_in` never change `q_hi`, and edges on `hi_in` never change `q_lo`. Falling edges on both inputs in the same cycle advance both sections.
- R6: When `clr_a` and `clr_b` are both 1 at a rising `clk` edge, both outputs are 0 after that edge, whatever the count inputs do.
- R7: Only one of `clr_a` or `clr_b` high has no effect on counting.
- R8: A falling edge seen while the clear is active is discarded. The first falling edge after the clear is released counts from 0.
- R9: With `q_lo` wired to `hi_in`, pulses on `lo_in` make {`q_hi`,`q_lo`} step through 0 to 15 and wrap to 0. The wide section follows one `clk` after `q_lo` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lo_in | input | 1 | Count input of the single-bit section, active on its falling edge |
| hi_in | input | 1 | Count input of the multi-bit section, active on its falling edge |
| clr_a | input | 1 | Clear qualifier, first of two |
| clr_b | input | 1 | Clear qualifier, second of two |
| q_lo | output | 1 | Divide-by-two output |
| q_hi | output | HI_BITS | Multi-bit section count, bit 0 the fastest |

## Verification
A wrong internal state shows on the outputs one system clock after the falling edge that produced it, because every bit is a registered output. A carry that stops at the wrong bit breaks the binary sequence at the 3-to-4 or 7-to-0 step of `q_hi`. A stale edge-detector state shows up as a count step taken on a rising edge, or as a step that is missed after a clear. In the chained mode, an error in the single bit appears in the wide section one clock later, so the checks are made only after the chain has settled.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  // high-to-low transition between two sampled levels
  function automatic logic fell_between(input logic prev_lvl, input logic cur_lvl);
    return prev_lvl & ~cur_lvl;
  endfunction
endpackage

// File: rtl/rsc_fall_detect.sv
module rsc_fall_detect
  import rsc_pkg::*;
(
  input  logic clk,
  input  logic lvl,
  output logic fell
);
  logic prev_q;

  // tracks the level in reset too, so a held-low input gives no edge at release
  always_ff @(posedge clk) prev_q <= lvl;

  always_comb fell = fell_between(prev_q, lvl);
endmodule

// File: rtl/rsc_toggle_cell.sv
module rsc_toggle_cell (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic trig,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (trig)  q <= ~q;
  end
endmodule

// File: rtl/rsc_hi_section.sv
module rsc_hi_section #(
  parameter int HI_BITS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               step,
  output logic [HI_BITS-1:0] q
);
  localparam int NCARRY = HI_BITS + 1;

  logic [NCARRY-1:0] carry;

  assign carry[0] = step;

  // bit k flips when every lower bit is 1 on a step, i.e. when bit k-1 falls
  for (genvar k = 0; k < HI_BITS; k++) begin : g_bit
    rsc_toggle_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .trig (carry[k]),
      .q    (q[k])
    );
    assign carry[k+1] = carry[k] & q[k];
  end
endmodule

// File: rtl/ripple_split_counter.sv
module ripple_split_counter #(
  parameter int HI_BITS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lo_in,
  input  logic               hi_in,
  input  logic               clr_a,
  input  logic               clr_b,
  output logic               q_lo,
  output logic [HI_BITS-1:0] q_hi
);
  logic clr_both;
  logic lo_fell;
  logic hi_fell;

  assign clr_both = clr_a & clr_b;

  rsc_fall_detect u_lo_edge (.clk(clk), .lvl(lo_in), .fell(lo_fell));
  rsc_fall_detect u_hi_edge (.clk(clk), .lvl(hi_in), .fell(hi_fell));

  rsc_toggle_cell u_lo_cell (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_both),
    .trig (lo_fell),
    .q    (q_lo)
  );

  rsc_hi_section #(.HI_BITS(HI_BITS)) u_hi (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_both),
    .step (hi_fell),
    .q    (q_hi)
  );
endmodule

// File: rtl/ripple_split_counter_chk.sv
module ripple_split_counter_chk #(
  parameter int HI_BITS = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               lo_in,
  input logic               hi_in,
  input logic               clr_a,
  input logic               clr_b,
  input logic               q_lo,
  input logic [HI_BITS-1:0] q_hi
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (q_lo == 1'b0 && q_hi == '0));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_a && clr_b) |=> (q_lo == 1'b0 && q_hi == '0));

  // R2
  lo_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!(clr_a && clr_b) && $fell(lo_in)) |=> (q_lo != $past(q_lo)));

  // R3
  lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(clr_a && clr_b) && !$fell(lo_in)) |=> $stable(q_lo));

  // R4
  hi_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!(clr_a && clr_b) && $fell(hi_in)) |=> (q_hi == HI_BITS'($past(q_hi) + 1'b1)));

  // R5
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(clr_a && clr_b) && !$fell(hi_in)) |=> $stable(q_hi));
endmodule

bind ripple_split_counter ripple_split_counter_chk #(.HI_BITS(HI_BITS)) u_chk (.*);

// File: tb/ripple_split_counter_tb.sv
module ripple_split_counter_tb;
  localparam int HI_BITS = 3;
  localparam int NVEC    = 25;
  // entry: {lo_in, hi_in, clr_a, clr_b, exp_lo, exp_hi[2:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1100_0000, 8'b0100_1000, 8'b0000_1001, 8'b1100_1001, 8'b1000_1010,
    8'b0100_0010, 8'b0000_0011, 8'b1100_0011, 8'b0000_1100, 8'b1110_1100,
    8'b0001_0101, 8'b1100_0101, 8'b1000_0110, 8'b1100_0110, 8'b1000_0111,
    8'b1100_0111, 8'b1000_0000, 8'b1100_0000, 8'b0000_1001, 8'b1100_1001,
    8'b1000_1010, 8'b0111_0000, 8'b1011_0000, 8'b0100_1000, 8'b0000_1001
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lo_drv = 1'b0, hi_drv = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
  logic chain = 1'b0;
  logic hi_in;
  logic q_lo;
  logic [HI_BITS-1:0] q_hi;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign hi_in = chain ? q_lo : hi_drv;

  ripple_split_counter #(.HI_BITS(HI_BITS)) u_dut (
    .clk(clk), .rst(rst), .lo_in(lo_drv), .hi_in(hi_in),
    .clr_a(clr_a), .clr_b(clr_b), .q_lo(q_lo), .q_hi(q_hi)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    cycles(2);
    rst = 1'b0;
  endtask

  task automatic pulse_lo(input int settle);
    @(negedge clk); lo_drv = 1'b1;
    @(negedge clk); lo_drv = 1'b0;
    cycles(settle);
  endtask

  task automatic pulse_hi;
    @(negedge clk); hi_drv = 1'b1;
    @(negedge clk); hi_drv = 1'b0;
    cycles(1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ref_cnt;
    cycles(3);
    // R1: reset state
    chk("R1 reset", {q_hi, q_lo}, 4'd0);
    rst = 1'b0;
    cycles(1);

    // vector walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {lo_drv, hi_drv, clr_a, clr_b} = VEC[i][7:4];
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R5/R6/R7/R8 vec%0d", i), {q_hi, q_lo}, {VEC[i][2:0], VEC[i][3]});
    end
    clr_a = 1'b0; clr_b = 1'b0;

    // R1: reset in the middle of a count
    do_reset;
    cycles(1);
    chk("R1 mid reset", {q_hi, q_lo}, 4'd0);

    // R4: divide-by-8 alone over two wraps
    hi_drv = 1'b0; lo_drv = 1'b0;
    do_reset;
    ref_cnt = 0;
    for (int i = 0; i < 18; i++) begin
      pulse_hi;
      ref_cnt = (ref_cnt + 1) % 8;
      chk("R4 standalone", {1'b0, q_hi}, 4'(ref_cnt));
      chk("R5 lo untouched", {3'b0, q_lo}, 4'd0);
    end

    // R9: chained modulo-16 counter
    do_reset; rst = 1'b1; chain = 1'b1; cycles(2); rst = 1'b0;
    ref_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      pulse_lo(3);
      ref_cnt = (ref_cnt + 1) % 16;
      chk("R9 chained", {q_hi, q_lo}, 4'(ref_cnt));
    end

    // R8: clear in the middle of a chained count, then released
    @(negedge clk); clr_a = 1'b1; clr_b = 1'b1;
    cycles(3);
    chk("R6 chained clear", {q_hi, q_lo}, 4'd0);
    clr_a = 1'b0; clr_b = 1'b0;
    pulse_lo(3);
    chk("R8 after release", {q_hi, q_lo}, 4'd1);
    pulse_lo(3);
    chk("R9 after release", {q_hi, q_lo}, 4'd2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule